// File: doc/BRIEF.md
# TAI Timestamp Counter with Capture

This block keeps time of day in the reference clock domain as two counters. One counts whole TAI seconds. The other counts reference clock ticks within the current second: 8 ns ticks at 125 MHz, so 125,000,000 ticks make one second. When the tick counter reaches the last tick of the second, the next tick sets it back to zero and adds one to the seconds counter. A load strobe presets the seconds value and restarts the second at tick zero.

A device in an unrelated sample clock domain, such as an ADC data strobe, can ask for a timestamp. The block carries the request into the reference domain through a toggle-based pulse synchronizer. Then it latches both counters together as one snapshot.

The snapshot is held with a valid flag until the consumer acknowledges it. A request that lands while an unacknowledged snapshot is held does not replace that snapshot; it sets a sticky overflow flag instead. On the sample side, a busy flag shows when a request is still in flight. A strobe raised while busy is dropped.

Top module: `tai_stamp_unit`

## Requirements
- R1: While reset is asserted, the seconds and tick outputs read 0, and the valid, overflow and busy flags read 0.
- R2: On each reference clock cycle with no load, if the tick count is below TICKS_PER_SEC-1, it rises by exactly one and the seconds value is unchanged.
- R3: When the tick count equals TICKS_PER_SEC-1 and no load is present, the next cycle shows tick 0 and seconds plus one (modulo 2^40). The tick count never exceeds TICKS_PER_SEC-1.
- R4: A load strobe makes the next cycle show the loaded seconds value and tick 0. A load takes priority over the end-of-second wrap.
- R5: A one-cycle strobe in the sample domain produces exactly one snapshot. The snapshot is a seconds/tick pair the counters actually held. Its linear time (seconds×TICKS_PER_SEC+tick) lies between the count at the strobe and ten ticks later.
- R6: After an accepted strobe, busy is high on the next sample clock cycle. Busy falls once the request has been seen in the reference domain. A strobe while busy is ignored: it yields no second snapshot.
- R7: Valid stays high and the snapshot stays unchanged until acknowledge. The cycle after the acknowledge shows valid low.
- R8: A capture arriving while valid is high leaves the snapshot unchanged and sets the overflow flag. The flag stays set until the next acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (125 MHz) |
| rst_ref | input | 1 | Synchronous active-high reset, reference domain |
| clk_smp | input | 1 | Sample domain clock |
| rst_smp | input | 1 | Synchronous active-high reset, sample domain |
| smp_strobe_i | input | 1 | Capture request, sample domain |
| smp_busy_o | output | 1 | Request in flight, sample domain |
| load_en_i | input | 1 | Seconds preset strobe |
| load_sec_i | input | 40 | Seconds value to preset |
| sec_o | output | 40 | Running seconds |
| sub_o | output | 28 | Running tick within the second |
| cap_valid_o | output | 1 | Snapshot held |
| cap_sec_o | output | 40 | Snapshot seconds |
| cap_sub_o | output | 28 | Snapshot tick |
| cap_ack_i | input | 1 | Consumer acknowledge of snapshot |
| cap_ovf_o | output | 1 | Sticky capture overflow |

## Verification
The counters are compared on every cycle against a model of the counting rules. The stimulus covers:
- free running across several second boundaries, which tells plain increments apart from wraps;
- a preset to the all-ones seconds value, which shows that the seconds counter rolls over to zero;
- a load placed exactly on the last tick of a second, which shows that the load wins over the wrap.

Capture is tried in three ways:
- single strobes at random moments with random presets between them, which bound the snapshot inside the expected window;
- a strobe held for two sample cycles, which shows that the request made while busy is dropped;
- a second capture before acknowledge, which shows that the snapshot is kept and overflow is raised.

// File: rtl/tai_pkg.sv
package tai_pkg;

    localparam int unsigned SEC_W     = 40;
    localparam int unsigned SUB_W     = 28;
    localparam int unsigned TICKS_DEF = 125_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } tai_time_t;

    // One reference tick forward: wrap the sub-second part at 'last'.
    function automatic tai_time_t tai_advance(input tai_time_t cur,
                                              input logic [SUB_W-1:0] last);
        tai_time_t nxt;
        if (cur.sub == last) begin
            nxt.sub = '0;
            nxt.sec = cur.sec + 1'b1;
        end else begin
            nxt.sub = cur.sub + 1'b1;
            nxt.sec = cur.sec;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tai_time_counter.sv
module tai_time_counter
    import tai_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = TICKS_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output tai_time_t        now
);
    localparam logic [SUB_W-1:0] LAST_TICK = SUB_W'(TICKS_PER_SEC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (load_en) begin
            now.sec <= load_sec;
            now.sub <= '0;
        end else begin
            now <= tai_advance(now, LAST_TICK);
        end
    end

    assert_sub_range_R3: assert property (@(posedge clk) disable iff (rst)
        now.sub <= LAST_TICK);

    assert_sub_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!load_en && now.sub != LAST_TICK)
        |=> (now.sub == $past(now.sub) + 1'b1 && now.sec == $past(now.sec)));

    assert_wrap_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && now.sub == LAST_TICK)
        |=> (now.sub == '0 && now.sec == $past(now.sec) + 1'b1));

    assert_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (now.sub == '0 && now.sec == $past(load_sec)));

endmodule

// File: rtl/tai_pulse_sync.sv
module tai_pulse_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst,
    input  logic src_pulse,
    output logic src_busy,
    input  logic dst_clk,
    input  logic dst_rst,
    output logic dst_pulse
);
    logic              req_tgl;
    logic [STAGES:0]   dst_sync;
    logic [STAGES-1:0] ack_sync;

    // Source side: flip on an accepted request.
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            req_tgl <= 1'b0;
        end else if (src_pulse && !src_busy) begin
            req_tgl <= ~req_tgl;
        end
    end

    // Destination side: synchronizer stages plus one stage for edge detect.
    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            dst_sync <= '0;
        end else begin
            dst_sync <= {dst_sync[STAGES-1:0], req_tgl};
        end
    end

    assign dst_pulse = dst_sync[STAGES] ^ dst_sync[STAGES-1];

    // Acknowledge returns the recovered toggle to the source.
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            ack_sync <= '0;
        end else begin
            ack_sync <= {ack_sync[STAGES-2:0], dst_sync[STAGES]};
        end
    end

    assign src_busy = req_tgl ^ ack_sync[STAGES-1];

    assert_single_pulse_R5: assert property (@(posedge dst_clk) disable iff (dst_rst)
        dst_pulse |=> !dst_pulse);

    assert_busy_after_req_R6: assert property (@(posedge src_clk) disable iff (src_rst)
        (src_pulse && !src_busy) |=> src_busy);

endmodule

// File: rtl/tai_capture_latch.sv
module tai_capture_latch
    import tai_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_pulse,
    input  tai_time_t now,
    input  logic      ack,
    output tai_time_t snap,
    output logic      valid,
    output logic      ovf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            snap  <= '0;
            valid <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (cap_pulse && (!valid || ack)) begin
                snap  <= now;
                valid <= 1'b1;
            end else if (ack) begin
                valid <= 1'b0;
            end
            if (ack) begin
                ovf <= 1'b0;
            end else if (cap_pulse && valid) begin
                ovf <= 1'b1;
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(snap)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && !cap_pulse) |=> !valid);

    assert_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && cap_pulse && !ack) |=> (ovf && $stable(snap)));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ack) |=> ovf);

endmodule

// File: rtl/tai_stamp_unit.sv
module tai_stamp_unit
    import tai_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = TICKS_DEF,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic             clk_ref,
    input  logic             rst_ref,
    input  logic             clk_smp,
    input  logic             rst_smp,
    input  logic             smp_strobe_i,
    output logic             smp_busy_o,
    input  logic             load_en_i,
    input  logic [SEC_W-1:0] load_sec_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [SUB_W-1:0] sub_o,
    output logic             cap_valid_o,
    output logic [SEC_W-1:0] cap_sec_o,
    output logic [SUB_W-1:0] cap_sub_o,
    input  logic             cap_ack_i,
    output logic             cap_ovf_o
);
    tai_time_t now;
    tai_time_t snap;
    logic      cap_pulse;

    tai_time_counter #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_counter (
        .clk      (clk_ref),
        .rst      (rst_ref),
        .load_en  (load_en_i),
        .load_sec (load_sec_i),
        .now      (now)
    );

    tai_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .src_clk   (clk_smp),
        .src_rst   (rst_smp),
        .src_pulse (smp_strobe_i),
        .src_busy  (smp_busy_o),
        .dst_clk   (clk_ref),
        .dst_rst   (rst_ref),
        .dst_pulse (cap_pulse)
    );

    tai_capture_latch u_latch (
        .clk       (clk_ref),
        .rst       (rst_ref),
        .cap_pulse (cap_pulse),
        .now       (now),
        .ack       (cap_ack_i),
        .snap      (snap),
        .valid     (cap_valid_o),
        .ovf       (cap_ovf_o)
    );

    assign sec_o     = now.sec;
    assign sub_o     = now.sub;
    assign cap_sec_o = snap.sec;
    assign cap_sub_o = snap.sub;

endmodule

// File: tb/tb_tai_stamp_unit.sv
`timescale 1ns/1ps
module tb_tai_stamp_unit;
    localparam int unsigned TICKS = 1000;

    logic        clk_ref = 0, clk_smp = 0;
    logic        rst_ref = 1, rst_smp = 1;
    logic        smp_strobe_i = 0, load_en_i = 0, cap_ack_i = 0;
    logic [39:0] load_sec_i = '0;
    logic        smp_busy_o, cap_valid_o, cap_ovf_o;
    logic [39:0] sec_o, cap_sec_o;
    logic [27:0] sub_o, cap_sub_o;

    int checks = 0, errors = 0;
    bit mon_on = 0;

    always #4   clk_ref = ~clk_ref;
    always #6.5 clk_smp = ~clk_smp;

    tai_stamp_unit #(.TICKS_PER_SEC(TICKS)) dut (
        .clk_ref(clk_ref), .rst_ref(rst_ref), .clk_smp(clk_smp), .rst_smp(rst_smp),
        .smp_strobe_i(smp_strobe_i), .smp_busy_o(smp_busy_o),
        .load_en_i(load_en_i), .load_sec_i(load_sec_i),
        .sec_o(sec_o), .sub_o(sub_o), .cap_valid_o(cap_valid_o),
        .cap_sec_o(cap_sec_o), .cap_sub_o(cap_sub_o),
        .cap_ack_i(cap_ack_i), .cap_ovf_o(cap_ovf_o)
    );

    // Expected time from the counting rules of R2, R3, R4.
    logic [39:0] m_sec;
    logic [27:0] m_sub;
    int          m_kind;
    always @(posedge clk_ref) begin
        if (rst_ref) begin
            m_sec <= '0; m_sub <= '0; m_kind <= 0;
        end else if (load_en_i) begin
            m_sec <= load_sec_i; m_sub <= '0; m_kind <= 2;
        end else if (m_sub == 28'(TICKS - 1)) begin
            m_sec <= m_sec + 1; m_sub <= '0; m_kind <= 1;
        end else begin
            m_sub <= m_sub + 1; m_kind <= 0;
        end
    end

    function automatic logic [63:0] lin(input logic [39:0] s, input logic [27:0] t);
        return 64'(s) * 64'(TICKS) + 64'(t);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input logic [63:0] act,
                           input logic [63:0] lo, input logic [63:0] hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=[%0d..%0d]", tag, act, lo, hi);
        end
    endtask

    always @(negedge clk_ref) begin
        if (mon_on) begin
            case (m_kind)
                1:       begin chk("R3 wrap sec", sec_o, m_sec); chk("R3 wrap sub", sub_o, m_sub); end
                2:       begin chk("R4 load sec", sec_o, m_sec); chk("R4 load sub", sub_o, m_sub); end
                default: begin chk("R2 step sec", sec_o, m_sec); chk("R2 step sub", sub_o, m_sub); end
            endcase
        end
    end

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_ref);
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=completion");
        summary();
    end

    task automatic wait_valid;
        for (int i = 0; i < 40 && !cap_valid_o; i++) @(negedge clk_ref);
    endtask

    task automatic wait_idle;
        for (int i = 0; i < 40 && smp_busy_o; i++) @(negedge clk_smp);
        chk("R6 busy clears", smp_busy_o, 0);
    endtask

    task automatic do_ack;
        @(negedge clk_ref); cap_ack_i = 1;
        @(negedge clk_ref); cap_ack_i = 0;
        chk("R7 valid low after ack", cap_valid_o, 0);
        chk("R8 ovf cleared by ack", cap_ovf_o, 0);
    endtask

    // Strobe for one sample cycle; check the snapshot window.
    task automatic capture_one(input bit expect_new);
        logic [63:0] t0;
        @(negedge clk_smp);
        t0 = lin(m_sec, m_sub);
        smp_strobe_i = 1;
        @(negedge clk_smp);
        smp_strobe_i = 0;
        chk("R6 busy after strobe", smp_busy_o, 1);
        if (expect_new) begin
            wait_valid();
            chk("R5 valid raised", cap_valid_o, 1);
            chk_rng("R5 snapshot window", lin(cap_sec_o, cap_sub_o), t0, t0 + 10);
        end
    endtask

    initial begin
        logic [39:0] hs;
        logic [27:0] ht;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk_ref);
        chk("R1 sec reset", sec_o, 0);
        chk("R1 sub reset", sub_o, 0);
        chk("R1 valid reset", cap_valid_o, 0);
        chk("R1 ovf reset", cap_ovf_o, 0);
        chk("R1 busy reset", smp_busy_o, 0);
        @(negedge clk_ref); rst_ref = 0;
        @(negedge clk_smp); rst_smp = 0;
        @(negedge clk_ref); mon_on = 1;

        // Free run over second boundaries (R2, R3).
        repeat (2300) @(negedge clk_ref);

        // Seconds rollover from all ones (R3).
        load_sec_i = '1; load_en_i = 1;
        @(negedge clk_ref); load_en_i = 0;
        repeat (TICKS + 20) @(negedge clk_ref);
        chk("R3 seconds roll to zero", sec_o, 0);

        // Load on the last tick wins over the wrap (R4).
        while (m_sub != 28'(TICKS - 1)) @(negedge clk_ref);
        load_sec_i = 40'h12_3456_789A; load_en_i = 1;
        @(negedge clk_ref); load_en_i = 0;
        chk("R4 load beats wrap", sec_o, 40'h12_3456_789A);
        chk("R4 load clears tick", sub_o, 0);

        // Basic capture, hold until acknowledge (R5, R7).
        capture_one(1);
        hs = cap_sec_o; ht = cap_sub_o;
        repeat (7) @(negedge clk_ref);
        chk("R7 valid held", cap_valid_o, 1);
        chk("R7 snap sec held", cap_sec_o, hs);
        chk("R7 snap sub held", cap_sub_o, ht);
        wait_idle();
        do_ack();

        // Overflow: second capture before acknowledge (R8).
        capture_one(1);
        hs = cap_sec_o; ht = cap_sub_o;
        wait_idle();
        capture_one(0);
        repeat (12) @(negedge clk_ref);
        chk("R8 ovf set", cap_ovf_o, 1);
        chk("R8 snap sec kept", cap_sec_o, hs);
        chk("R8 snap sub kept", cap_sub_o, ht);
        repeat (5) @(negedge clk_ref);
        chk("R8 ovf sticky", cap_ovf_o, 1);
        wait_idle();
        do_ack();

        // Strobe held while busy is dropped (R6).
        @(negedge clk_smp); smp_strobe_i = 1;
        @(negedge clk_smp);
        @(negedge clk_smp); smp_strobe_i = 0;
        wait_valid();
        chk("R6 first request captured", cap_valid_o, 1);
        wait_idle();
        do_ack();
        repeat (30) @(negedge clk_ref);
        chk("R6 no second snapshot", cap_valid_o, 0);
        chk("R6 no overflow", cap_ovf_o, 0);

        // Random timing and presets mixed with captures.
        for (int n = 0; n < 25; n++) begin
            repeat ($urandom_range(0, 300)) @(negedge clk_ref);
            if ($urandom_range(0, 2) == 0) begin
                load_sec_i = {8'($urandom), 32'($urandom)} >> 1;
                load_en_i = 1;
                @(negedge clk_ref); load_en_i = 0;
                @(negedge clk_ref);
            end
            capture_one(1);
            repeat ($urandom_range(0, 20)) @(negedge clk_ref);
            wait_idle();
            do_ack();
        end

        mon_on = 0;
        summary();
    end
endmodule